// File: doc/BRIEF.md
# Calibrated RTC Prescaler Chain

This block is the timebase of a real-time clock. A low-frequency clock enable (nominally 32768 pulses per second, one per enabled cycle of the system clock) feeds a first divider. That divider produces an uncorrected 128 Hz tick. The 128 Hz tick steps a second counter, which gives a 64 Hz tick and a 1 Hz tick. Calendar logic elsewhere consumes these ticks.

Crystal error is trimmed digitally over a fixed window of 64 minutes. A direction bit and a 6-bit magnitude are captured when each window begins. In the slowing direction, the second counter skips its advance on some first-stage ticks. In the speeding direction, it advances by two instead of one on some first-stage ticks. The affected ticks are consecutive, starting at a fixed tick offset inside the window. Even at magnitude zero some correction is applied.

Only the 64 Hz and 1 Hz ticks see the correction. A consumer that needs a perfectly regular fast rate must derive it from the 128 Hz tick.

Top module: `rtc_prescale_cal`

## Requirements
- R1: `tick_128` pulses on every DIV1-th enabled cycle. The first pulse comes on the DIV1-th enabled cycle after reset. Its rate never depends on the calibration inputs.
- R2: The second stage keeps a position that normally advances by 1 per `tick_128`. `tick_64` pulses once each time the position passes a multiple of 2. `tick_1` pulses once each time it passes a multiple of 2^SUB_W.
- R3: A window is WIN_TICKS first-stage ticks long. Corrections fall on consecutive first-stage ticks, starting at tick index CAL_OFFSET of the window (indices count from 0).
- R4: With `cal_up`=0 (slowing), each window holds the position on 2×(mag+1) first-stage ticks. On a held tick the position does not advance.
- R5: With `cal_up`=1 (speeding), each window advances the position by 2 on 4×(mag+1) first-stage ticks.
- R6: At `cal_mag`=0 the correction is still nonzero: 2 holds when slowing, 4 double steps when speeding.
- R7: Every tick output is a single-cycle pulse. A tick output is high only in a cycle where `lf_en` is high.
- R8: `cal_up` and `cal_mag` are captured during reset and again at the last first-stage tick of each window. A change made inside a window affects only the following window.
- R9: While `rst_n` is low, all tick outputs are low. Reset clears both counters and the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lf_en | input | 1 | One pulse per low-frequency input cycle |
| cal_up | input | 1 | Correction direction: 0 slows, 1 speeds up |
| cal_mag | input | 6 | Correction magnitude |
| tick_128 | output | 1 | Uncorrected first-stage tick |
| tick_64 | output | 1 | Corrected half-rate tick |
| tick_1 | output | 1 | Corrected once-per-wrap tick |

## Verification
The embedded properties take three things for granted. CAL_OFFSET plus the largest event count, 4×2^6, must fit inside WIN_TICKS, so that every correction finishes before the window wraps. The hold and double-step requests are never raised together. The calibration inputs are only looked at on window boundaries. The stimulus is built to respect these conditions. It uses a short window of 512 ticks with an offset of 16, which leaves room for 256 speeding events. It changes the calibration inputs only halfway through a window. It gates `lf_en` off on every third cycle, so that both gated and ungated cycles occur next to ticks.

// File: rtl/rtc_cal_pkg.sv
// Package: shared types for the calibrated prescaler chain.
// Assumes: magnitude field width is fixed by the register layout.
package rtc_cal_pkg;
    localparam int CAL_MAG_W = 6;

    typedef enum logic {
        CAL_SLOW = 1'b0,
        CAL_FAST = 1'b1
    } cal_dir_e;

    // Number of correction events one window carries for a given setting.
    function automatic logic [CAL_MAG_W+2:0] cal_events(input cal_dir_e dir,
                                                        input logic [CAL_MAG_W-1:0] mag);
        logic [CAL_MAG_W+2:0] base;
        base = {3'b000, mag} + 1'b1;
        return (dir == CAL_FAST) ? (base << 2) : (base << 1);
    endfunction
endpackage

// File: rtl/rtc_div_stage.sv
// First stage: divides the low-frequency enable by DIV and emits a tick
// on the last enabled cycle of each period.
// Assumes: DIV >= 2; lf_en is synchronous to clk.
module rtc_div_stage #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lf_en,
    output logic tick_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count enabled cycles modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (lf_en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Tick on the final enabled cycle of each period.
    always_comb tick_o = lf_en && (cnt == LAST);

    // R1: the divider only moves on enabled cycles
    a_r1_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !lf_en |=> $stable(cnt));
    // R1: a tick always restarts the period
    a_r1_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt == '0);
endmodule

// File: rtl/rtc_cal_sched.sv
// Calibration scheduler: tracks the position inside the correction window
// (in first-stage ticks), captures the setting at each window start and
// issues hold or double-step requests on consecutive ticks from CAL_OFFSET.
// Assumes: CAL_OFFSET + 4*2^MAG_W <= WIN_TICKS.
module rtc_cal_sched
    import rtc_cal_pkg::*;
#(
    parameter int WIN_TICKS  = 491520,
    parameter int CAL_OFFSET = 4864
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  cal_dir_e             dir_i,
    input  logic [CAL_MAG_W-1:0] mag_i,
    output logic                 hold_o,
    output logic                 bump_o
);
    localparam int WW = $clog2(WIN_TICKS);
    localparam int EW = CAL_MAG_W + 3;
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_TICKS - 1);
    localparam logic [WW-1:0] OFS      = WW'(CAL_OFFSET);

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] ev_left;
    cal_dir_e      dir_q;
    logic          win_last;
    logic          fire;

    // Decode window end and whether this tick carries a correction.
    always_comb begin
        win_last = (win_cnt == WIN_LAST);
        fire     = tick_i && (win_cnt >= OFS) && (ev_left != '0);
    end

    // Window position, captured direction and remaining correction events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            dir_q   <= dir_i;
            ev_left <= cal_events(dir_i, mag_i);
        end else if (tick_i) begin
            if (win_last) begin
                win_cnt <= '0;
                dir_q   <= dir_i;
                ev_left <= cal_events(dir_i, mag_i);
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (fire)
                    ev_left <= ev_left - 1'b1;
            end
        end
    end

    // Route a firing tick to the request that matches the captured direction.
    always_comb begin
        hold_o = fire && (dir_q == CAL_SLOW);
        bump_o = fire && (dir_q == CAL_FAST);
    end

    // R8: the captured direction changes only at a window boundary
    a_r8_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && win_last) |=> $stable(dir_q));
    // R8: the event budget never grows inside a window
    a_r8_budget_drains: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && win_last) |=> ev_left <= $past(ev_left));
    // R3: no correction before the offset
    a_r3_no_early_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt < OFS) |-> !(hold_o || bump_o));
    // R3: the budget is spent before the window wraps
    a_r3_spent_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && win_last) |-> ev_left == '0);
endmodule

// File: rtl/rtc_sub_stage.sv
// Second stage: counts first-stage ticks, freezing on a hold request and
// stepping by two on a bump request; emits half-rate and wrap ticks.
// Assumes: hold and bump are never raised together.
module rtc_sub_stage #(
    parameter int SUB_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic bump_i,
    output logic half_o,
    output logic wrap_o
);
    logic [SUB_W-1:0] cnt;
    logic [SUB_W:0]   sum;
    logic [SUB_W-1:0] nxt;
    logic             adv;

    // Next position, crossing of even boundaries and carry out.
    always_comb begin
        adv    = tick_i && !hold_i;
        sum    = {1'b0, cnt} + (bump_i ? (SUB_W+1)'(2) : (SUB_W+1)'(1));
        nxt    = sum[SUB_W-1:0];
        half_o = adv && (nxt[SUB_W-1:1] != cnt[SUB_W-1:1]);
        wrap_o = adv && sum[SUB_W];
    end

    // Advance the position on every non-held tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (adv)
            cnt <= nxt;
    end

    // R4: a held tick leaves the position unchanged
    a_r4_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hold_i) |=> $stable(cnt));
    // R5: a bumped tick advances the position by two
    a_r5_bump_two: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && bump_i) |=> cnt == $past(cnt) + SUB_W'(2));
    // R4: the two requests are exclusive
    a_r4_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_i && bump_i));
    // R2: a wrap is always also a half-rate crossing
    a_r2_wrap_in_half: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> half_o);
    // R2: the half-rate tick only follows a first-stage tick
    a_r2_half_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        half_o |-> tick_i);
endmodule

// File: rtl/rtc_prescale_cal.sv
// Top: first-stage divider, calibration scheduler and second stage.
// Assumes: lf_en pulses at the low-frequency rate; CAL_OFFSET plus the
// largest event count fits in WIN_TICKS.
module rtc_prescale_cal
    import rtc_cal_pkg::*;
#(
    parameter int DIV1       = 256,
    parameter int SUB_W      = 7,
    parameter int WIN_TICKS  = 491520,
    parameter int CAL_OFFSET = 4864
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lf_en,
    input  logic                 cal_up,
    input  logic [CAL_MAG_W-1:0] cal_mag,
    output logic                 tick_128,
    output logic                 tick_64,
    output logic                 tick_1
);
    logic     base_tick;
    logic     hold_req;
    logic     bump_req;
    cal_dir_e dir_in;

    // Map the raw direction bit onto the shared enum.
    always_comb dir_in = cal_up ? CAL_FAST : CAL_SLOW;

    rtc_div_stage #(.DIV(DIV1)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .lf_en  (lf_en),
        .tick_o (base_tick)
    );

    rtc_cal_sched #(.WIN_TICKS(WIN_TICKS), .CAL_OFFSET(CAL_OFFSET)) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (base_tick),
        .dir_i  (dir_in),
        .mag_i  (cal_mag),
        .hold_o (hold_req),
        .bump_o (bump_req)
    );

    rtc_sub_stage #(.SUB_W(SUB_W)) u_sub (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (base_tick),
        .hold_i (hold_req),
        .bump_i (bump_req),
        .half_o (tick_64),
        .wrap_o (tick_1)
    );

    // Expose the uncorrected tick.
    always_comb tick_128 = base_tick;

    // R7: every tick output is qualified by the enable
    a_r7_ticks_need_en: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_128 || tick_64 || tick_1) |-> lf_en);
    // R1: calibration never removes a first-stage tick behind a corrected one
    a_r1_fast_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
        tick_64 |-> tick_128);
endmodule

// File: tb/test_rtc_prescale_cal.sv
module test_rtc_prescale_cal;
    localparam int DIV  = 4;
    localparam int SW   = 7;
    localparam int WIN  = 512;
    localparam int OFS  = 16;
    localparam int WD   = WIN * DIV;
    localparam int NWIN = 7;

    typedef struct {
        int    n128;
        int    n64;
        int    n1;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_en = 1'b0;
    logic       cal_up = 1'b0;
    logic [5:0] cal_mag = 6'd0;
    logic       tick_128, tick_64, tick_1;

    exp_t   sb_q[$];
    int     checks = 0;
    int     failures = 0;
    int     ecnt = 0;
    int     c128 = 0, c64 = 0, c1 = 0;
    int     last128 = 0;
    int     first128 = -1;
    int     bad_gap = 0;
    int     en_low_pulse = 0;
    int     rst_pulse = 0;
    bit     done = 1'b0;
    longint pos = 0;

    always #4 clk = ~clk;

    rtc_prescale_cal #(.DIV1(DIV), .SUB_W(SW), .WIN_TICKS(WIN), .CAL_OFFSET(OFS)) i_rtc_prescale_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .lf_en    (lf_en),
        .cal_up   (cal_up),
        .cal_mag  (cal_mag),
        .tick_128 (tick_128),
        .tick_64  (tick_64),
        .tick_1   (tick_1)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Enable pattern: off on every third cycle, driven after the edge.
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            lf_en = (cyc % 3) != 2;
            cyc++;
        end
    end

    // Driver: pushes the expected counts for each window from the setting
    // in force at its start (R8), then changes the setting mid-window.
    initial begin
        bit dirs[NWIN] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        int mags[NWIN] = '{0, 0, 63, 63, 5, 20, 1};
        cal_up  = dirs[0];
        cal_mag = 6'(mags[0]);
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int k = 0; k < NWIN; k++) begin
            exp_t e;
            longint adv, p0;
            adv = dirs[k] ? WIN + 4 * (mags[k] + 1) : WIN - 2 * (mags[k] + 1);
            p0  = pos;
            pos = pos + adv;
            e.n128 = WIN;
            e.n64  = int'(pos / 2 - p0 / 2);
            e.n1   = int'(pos / 128 - p0 / 128);
            e.tag  = dirs[k] ? ((mags[k] == 0) ? "R5/R6/R8" : "R5/R8")
                             : ((mags[k] == 0) ? "R4/R6/R8" : "R4/R8");
            sb_q.push_back(e);
            wait (ecnt >= k * WD + WD / 2);
            if (k + 1 < NWIN) begin
                cal_up  = dirs[k+1];
                cal_mag = 6'(mags[k+1]);
            end
            wait (ecnt >= (k + 1) * WD);
        end
        @(negedge clk);
        check("R9 no tick during reset", rst_pulse, 0);
        check("R1 first tick_128 enabled cycle", first128, DIV);
        check("R1 tick_128 spacing violations", bad_gap, 0);
        check("R7 pulses with lf_en low", en_low_pulse, 0);
        check("R3 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

    // Monitor: counts pulses per window and compares against the scoreboard.
    always @(negedge clk) begin
        if (!rst_n) begin
            if (tick_128 || tick_64 || tick_1) rst_pulse++;
        end else if (!lf_en) begin
            if (tick_128 || tick_64 || tick_1) en_low_pulse++;
        end else begin
            ecnt++;
            if (tick_128) begin
                c128++;
                if (first128 < 0) first128 = ecnt;
                else if (ecnt - last128 != DIV) bad_gap++;
                last128 = ecnt;
            end
            if (tick_64) c64++;
            if (tick_1) c1++;
            if (ecnt % WD == 0) begin
                if (sb_q.size() == 0) begin
                    check("R3 window without expectation", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({"R1 tick_128 per window ", e.tag}, c128, e.n128);
                    check({"R2 tick_64 per window ", e.tag}, c64, e.n64);
                    check({"R2 tick_1 per window ", e.tag}, c1, e.n1);
                end
                c128 = 0;
                c64  = 0;
                c1   = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule